// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block sits between the shared interrupt lines of a multiprocessor system and the local interrupt interfaces of its processors. Each shared line (interrupt IDs 32 and up) has a routing word that either pins the interrupt to one named processor or leaves it to automatic delivery. In automatic delivery, every enabled processor that is free is offered the interrupt. The first claim removes it from all the others. Each processor sees at most one offer at a time, carrying the lowest pending ID that is routed to it. A processor holds at most one claimed shared interrupt until it signals end of service.

Software writes 32-bit words through a simple write port. One word holds the global enable. One block of words holds the routing targets. One word raises inter-processor interrupts: a write to it pulses a set request with a private ID to each processor selected in its mask, in the same cycle as the write. Trigger detection is left to the local interfaces, so the shared inputs here are treated as level requests.

Top module: `shared_irq_dist`

## Requirements
- R1: The routing word of shared interrupt index k (ID 32+k) is written at byte address 0x1000 + 4*k for k below NUM_SHARED. After reset every routing word selects automatic delivery.
- R2: A routing word with bit 31 set and bits 30:0 below NUM_CPU delivers the interrupt to that one processor only.
- R3: A routing word of 0 selects automatic delivery. The interrupt is offered to every processor that is enabled and not busy.
- R4: Any other routing word (bit 31 set with a processor number of NUM_CPU or more, or bit 31 clear with a nonzero value) delivers the interrupt nowhere.
- R5: Bit 0 of the control word at address 0x0 enables shared delivery. It is 0 after reset, and while it is 0 no processor is offered a shared interrupt.
- R6: A processor whose `cpu_en` bit is low, or which holds a claimed interrupt, receives no offer.
- R7: When several interrupts are pending for a processor, the lowest index is offered. `irq_id` for processor c is 32 plus that index, in bits 8c+7:8c.
- R8: Driving `claim` while `irq_req` is high grants in the same cycle. From the next cycle that interrupt is in service and offered to nobody, and that processor is busy.
- R9: When several processors claim the same ID in one cycle, only the lowest-numbered one is granted. The others stay free.
- R10: An `eoi` pulse from a busy processor ends its service. If its line is still high, the interrupt is offered again from the next cycle.
- R11: A write to address 0x10 raises `ipi_set` for each processor c whose bit 8+c is set. `ipi_id` carries bits 3:0 of the word, in the same cycle and regardless of the global enable. No other write raises `ipi_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 16 | Byte address of the write |
| reg_wdata | input | 32 | Write data |
| irq_line | input | NUM_SHARED | Shared interrupt request lines, level |
| cpu_en | input | NUM_CPU | Local interface enable per processor |
| claim | input | NUM_CPU | Claim of the current offer per processor |
| eoi | input | NUM_CPU | End of service per processor |
| irq_req | output | NUM_CPU | Offer valid per processor |
| irq_id | output | 8*NUM_CPU | Offered interrupt ID per processor |
| claim_grant | output | NUM_CPU | Claim accepted this cycle |
| ipi_set | output | NUM_CPU | Inter-processor interrupt set pulse per processor |
| ipi_id | output | 4 | Private ID for the set pulse |

## Verification
The routing logic is exercised with a table of routing words paired with processor enable masks. The table separates automatic delivery from a named processor, a named processor that is disabled, a processor number out of range (including one that only high bits make invalid), and a nonzero word without bit 31. Directed sequences then place several lines pending at once to expose the priority order. Two processors claim the same automatic interrupt in one cycle to show arbitration. After that, end of service re-offers a still-high line. Inter-processor writes are driven with the global enable cleared to show that fan-out does not depend on it, and a plain control write shows that no stray pulse appears.

// File: rtl/sid_pkg.sv
package sid_pkg;

    localparam int ADDR_W      = 16;
    localparam int ID_W        = 8;
    localparam int PRIV_W      = 4;
    localparam int SHARED_BASE = 32;
    localparam int MAX_CPU     = 8;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 16'h0000;
    localparam logic [ADDR_W-1:0] OFF_IPI  = 16'h0010;
    localparam logic [ADDR_W-1:0] OFF_TGT  = 16'h1000;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_AUTO = 2'd1,
        ROUTE_ONE  = 2'd2
    } route_e;

    typedef struct packed {
        route_e     mode;
        logic [7:0] cpu;
    } route_t;

    localparam route_t ROUTE_RESET = '{mode: ROUTE_AUTO, cpu: 8'd0};

    // Reduce a 32-bit routing word to the compact form kept per interrupt.
    function automatic route_t decode_target(input logic [31:0] word, input int ncpu);
        route_t r;
        r.mode = ROUTE_NONE;
        r.cpu  = 8'd0;
        if (word == 32'd0) begin
            r.mode = ROUTE_AUTO;
        end else if (word[31] && (word[30:0] < 31'(ncpu))) begin
            r.mode = ROUTE_ONE;
            r.cpu  = word[7:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/sid_regs.sv
module sid_regs
    import sid_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int NUM_SHARED = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic                 glob_en,
    output route_t               route [NUM_SHARED],
    output logic [NUM_CPU-1:0]   ipi_set,
    output logic [PRIV_W-1:0]    ipi_id
);
    localparam int IDX_W = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;

    logic [ADDR_W-1:0] tgt_off;
    logic              tgt_hit;
    logic [IDX_W-1:0]  tgt_idx;
    route_t            tgt_new;

    assign tgt_off = addr - OFF_TGT;
    assign tgt_idx = tgt_off[IDX_W+1:2];
    assign tgt_hit = wr_en && (addr >= OFF_TGT) && (addr[1:0] == 2'b00)
                     && ((tgt_off >> 2) < ADDR_W'(NUM_SHARED));
    assign tgt_new = decode_target(wdata, NUM_CPU);

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en <= 1'b0;
        end else if (wr_en && addr == OFF_CTRL) begin
            glob_en <= wdata[0];
        end
    end

    for (genvar k = 0; k < NUM_SHARED; k++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (rst) begin
                route[k] <= ROUTE_RESET;
            end else if (tgt_hit && tgt_idx == IDX_W'(k)) begin
                route[k] <= tgt_new;
            end
        end
    end

    // Inter-processor fan-out is a same-cycle decode of the write.
    always_comb begin
        ipi_set = '0;
        ipi_id  = wdata[PRIV_W-1:0];
        if (wr_en && addr == OFF_IPI) begin
            ipi_set = wdata[8 +: NUM_CPU];
        end
    end

endmodule

// File: rtl/sid_select.sv
module sid_select
    import sid_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int NUM_SHARED = 32,
    localparam int IDX_W     = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1
) (
    input  logic [NUM_SHARED-1:0] pend,
    input  route_t                route [NUM_SHARED],
    input  logic [NUM_CPU-1:0]    cpu_en,
    input  logic [NUM_CPU-1:0]    busy,
    output logic [NUM_CPU-1:0]    req,
    output logic [IDX_W-1:0]      idx [NUM_CPU]
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_SHARED-1:0] elig;

        always_comb begin
            for (int k = 0; k < NUM_SHARED; k++) begin
                elig[k] = pend[k] && cpu_en[c] && !busy[c] &&
                          ((route[k].mode == ROUTE_AUTO) ||
                           (route[k].mode == ROUTE_ONE && route[k].cpu == 8'(c)));
            end
        end

        // Lowest index wins: scan downward so the last hit is the smallest.
        always_comb begin
            req[c] = 1'b0;
            idx[c] = '0;
            for (int k = NUM_SHARED - 1; k >= 0; k--) begin
                if (elig[k]) begin
                    req[c] = 1'b1;
                    idx[c] = IDX_W'(k);
                end
            end
        end
    end

endmodule

// File: rtl/sid_claim.sv
module sid_claim #(
    parameter int NUM_CPU    = 4,
    parameter int NUM_SHARED = 32,
    localparam int IDX_W     = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CPU-1:0]    claim,
    input  logic [NUM_CPU-1:0]    eoi,
    input  logic [NUM_CPU-1:0]    req,
    input  logic [IDX_W-1:0]      idx [NUM_CPU],
    output logic [NUM_SHARED-1:0] active,
    output logic [NUM_CPU-1:0]    busy,
    output logic [NUM_CPU-1:0]    grant
);
    logic [IDX_W-1:0] svc [NUM_CPU];

    // A claim loses to any lower-numbered processor claiming the same ID.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_arb
        always_comb begin
            grant[c] = claim[c] && req[c];
            for (int j = 0; j < c; j++) begin
                if (claim[j] && req[j] && idx[j] == idx[c]) begin
                    grant[c] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
            busy   <= '0;
            for (int c = 0; c < NUM_CPU; c++) begin
                svc[c] <= '0;
            end
        end else begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (eoi[c] && busy[c]) begin
                    active[svc[c]] <= 1'b0;
                    busy[c]        <= 1'b0;
                end
            end
            for (int c = 0; c < NUM_CPU; c++) begin
                if (grant[c]) begin
                    active[idx[c]] <= 1'b1;
                    busy[c]        <= 1'b1;
                    svc[c]         <= idx[c];
                end
            end
        end
    end

endmodule

// File: rtl/shared_irq_dist.sv
module shared_irq_dist
    import sid_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int NUM_SHARED = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_wr_en,
    input  logic [15:0]               reg_addr,
    input  logic [31:0]               reg_wdata,
    input  logic [NUM_SHARED-1:0]     irq_line,
    input  logic [NUM_CPU-1:0]        cpu_en,
    input  logic [NUM_CPU-1:0]        claim,
    input  logic [NUM_CPU-1:0]        eoi,
    output logic [NUM_CPU-1:0]        irq_req,
    output logic [NUM_CPU*8-1:0]      irq_id,
    output logic [NUM_CPU-1:0]        claim_grant,
    output logic [NUM_CPU-1:0]        ipi_set,
    output logic [3:0]                ipi_id
);
    localparam int IDX_W = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;

    logic                  glob_en;
    route_t                route   [NUM_SHARED];
    logic [NUM_SHARED-1:0] active;
    logic [NUM_SHARED-1:0] pend;
    logic [NUM_CPU-1:0]    busy;
    logic [IDX_W-1:0]      sel_idx [NUM_CPU];

    sid_regs #(.NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .glob_en (glob_en),
        .route   (route),
        .ipi_set (ipi_set),
        .ipi_id  (ipi_id)
    );

    assign pend = irq_line & ~active & {NUM_SHARED{glob_en}};

    sid_select #(.NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED)) sel_i (
        .pend   (pend),
        .route  (route),
        .cpu_en (cpu_en),
        .busy   (busy),
        .req    (irq_req),
        .idx    (sel_idx)
    );

    sid_claim #(.NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED)) claim_i (
        .clk    (clk),
        .rst    (rst),
        .claim  (claim),
        .eoi    (eoi),
        .req    (irq_req),
        .idx    (sel_idx),
        .active (active),
        .busy   (busy),
        .grant  (claim_grant)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_id
        assign irq_id[c*8 +: 8] = 8'(SHARED_BASE) + 8'(sel_idx[c]);
    end

    if (NUM_CPU > MAX_CPU) begin : g_bad_cfg
        initial $error("NUM_CPU exceeds the 8-bit destination mask");
    end

endmodule

// File: rtl/sid_checker.sv
module sid_checker #(
    parameter int NUM_CPU    = 4,
    parameter int NUM_SHARED = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 glob_en,
    input logic                 reg_wr_en,
    input logic [NUM_CPU-1:0]   cpu_en,
    input logic [NUM_CPU-1:0]   busy,
    input logic [NUM_CPU-1:0]   claim,
    input logic [NUM_CPU-1:0]   irq_req,
    input logic [NUM_CPU*8-1:0] irq_id,
    input logic [NUM_CPU-1:0]   claim_grant,
    input logic [NUM_CPU-1:0]   ipi_set
);
    // R5
    glob_off_chk: assert property (@(posedge clk) disable iff (rst)
        !glob_en |-> irq_req == '0);

    // R6
    offer_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req & ~(cpu_en & ~busy)) == '0);

    // R8
    grant_src_chk: assert property (@(posedge clk) disable iff (rst)
        (claim_grant & ~(claim & irq_req)) == '0);

    // R8
    grant_busy_chk: assert property (@(posedge clk) disable iff (rst)
        claim_grant != '0 |=> (irq_req & $past(claim_grant)) == '0);

    // R11
    ipi_src_chk: assert property (@(posedge clk) disable iff (rst)
        ipi_set != '0 |-> reg_wr_en);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
        // R7
        id_range_chk: assert property (@(posedge clk) disable iff (rst)
            irq_req[c] |-> (irq_id[c*8 +: 8] >= 8'd32) &&
                           (irq_id[c*8 +: 8] < 8'(32 + NUM_SHARED)));
        for (genvar j = c + 1; j < NUM_CPU; j++) begin : g_j
            // R9
            one_winner_chk: assert property (@(posedge clk) disable iff (rst)
                (claim_grant[c] && claim_grant[j]) |->
                    irq_id[c*8 +: 8] != irq_id[j*8 +: 8]);
        end
    end

endmodule

bind shared_irq_dist sid_checker #(.NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .glob_en     (glob_en),
    .reg_wr_en   (reg_wr_en),
    .cpu_en      (cpu_en),
    .busy        (busy),
    .claim       (claim),
    .irq_req     (irq_req),
    .irq_id      (irq_id),
    .claim_grant (claim_grant),
    .ipi_set     (ipi_set)
);

// File: tb/shared_irq_dist_tb_top.sv
module shared_irq_dist_tb_top;
    localparam int NC = 4;
    localparam int NS = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [15:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [NS-1:0] irq_line = '0;
    logic [NC-1:0] cpu_en = '0;
    logic [NC-1:0] claim = '0;
    logic [NC-1:0] eoi = '0;
    logic [NC-1:0] irq_req;
    logic [NC*8-1:0] irq_id;
    logic [NC-1:0] claim_grant;
    logic [NC-1:0] ipi_set;
    logic [3:0]    ipi_id;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    shared_irq_dist #(.NUM_CPU(NC), .NUM_SHARED(NS)) dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .irq_line(irq_line), .cpu_en(cpu_en),
        .claim(claim), .eoi(eoi), .irq_req(irq_req), .irq_id(irq_id),
        .claim_grant(claim_grant), .ipi_set(ipi_set), .ipi_id(ipi_id)
    );

    // Vector: routing word [39:8], cpu_en [7:4], expected irq_req [3:0]
    localparam logic [39:0] VEC [8] = '{
        {32'h0000_0000, 4'b1111, 4'b1111},  // R3 automatic, all enabled
        {32'h0000_0000, 4'b0101, 4'b0101},  // R3 R6 automatic, two enabled
        {32'h8000_0002, 4'b1111, 4'b0100},  // R2 named processor 2
        {32'h8000_0003, 4'b0111, 4'b0000},  // R6 named processor disabled
        {32'h8000_0004, 4'b1111, 4'b0000},  // R4 number equal to N
        {32'h0000_0006, 4'b1111, 4'b0000},  // R4 bit 31 clear, nonzero
        {32'h8000_0000, 4'b1111, 4'b0001},  // R2 named processor 0
        {32'h8000_0100, 4'b1111, 4'b0000}   // R4 high bits out of range
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [7:0] id_of(input int c);
        return irq_id[c*8 +: 8];
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        chk(irq_req == '0, "R5 reset no offers", 32'(irq_req), 0);
        chk(ipi_set == '0, "R11 reset no ipi", 32'(ipi_set), 0);

        // Global enable off: line high, automatic, no offers
        cpu_en = 4'b1111; irq_line[0] = 1'b1;
        @(negedge clk); #1;
        chk(irq_req == '0, "R5 disabled blocks offers", 32'(irq_req), 0);
        wr(16'h0000, 32'h1);
        #1;
        chk(irq_req == 4'b1111, "R5 enabled offers", 32'(irq_req), 32'hF);
        irq_line = '0;

        // Routing table on interrupt index 0 (ID 32)
        for (int v = 0; v < 8; v++) begin
            wr(16'h1000, VEC[v][39:8]);
            cpu_en = VEC[v][7:4];
            irq_line[0] = 1'b1;
            #1;
            chk(irq_req == VEC[v][3:0], $sformatf("R2/R3/R4/R6 route vector %0d", v),
                32'(irq_req), 32'(VEC[v][3:0]));
            for (int c = 0; c < NC; c++) begin
                if (VEC[v][c]) chk(id_of(c) == 8'd32, "R7 id of routed line", 32'(id_of(c)), 32);
            end
            @(negedge clk);
            irq_line = '0;
        end

        // Priority: lines 3 and 5 under default automatic routing
        cpu_en = 4'b1111;
        @(negedge clk);
        irq_line[3] = 1'b1; irq_line[5] = 1'b1;
        #1;
        chk(id_of(2) == 8'd35, "R7 lowest pending first", 32'(id_of(2)), 35);

        // Processor 1 claims ID 35
        @(negedge clk);
        claim = 4'b0010;
        #1;
        chk(claim_grant == 4'b0010, "R8 same-cycle grant", 32'(claim_grant), 32'h2);
        @(negedge clk);
        claim = '0;
        #1;
        chk(irq_req == 4'b1101, "R8 claimer busy", 32'(irq_req), 32'hD);
        chk(id_of(0) == 8'd37, "R8 claimed id withdrawn", 32'(id_of(0)), 37);

        // Processors 0 and 2 claim ID 37 together
        @(negedge clk);
        claim = 4'b0101;
        #1;
        chk(claim_grant == 4'b0001, "R9 lowest processor wins", 32'(claim_grant), 32'h1);
        @(negedge clk);
        claim = '0;
        #1;
        chk(irq_req == 4'b0000, "R9 nothing left pending", 32'(irq_req), 0);
        irq_line[6] = 1'b1;
        #1;
        chk(irq_req == 4'b1100, "R9 loser stays free", 32'(irq_req), 32'hC);
        chk(id_of(3) == 8'd38, "R9 new line offered", 32'(id_of(3)), 38);

        // End of service from processor 1; line 3 still high
        @(negedge clk);
        eoi = 4'b0010;
        @(negedge clk);
        eoi = '0;
        #1;
        chk(irq_req == 4'b1110, "R10 eoi frees processor", 32'(irq_req), 32'hE);
        chk(id_of(1) == 8'd35, "R10 line re-offered", 32'(id_of(1)), 35);

        // IPI with the global enable cleared
        wr(16'h0000, 32'h0);
        #1;
        chk(irq_req == '0, "R5 cleared enable", 32'(irq_req), 0);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 16'h0010; reg_wdata = 32'h0000_0A0F;
        #1;
        chk(ipi_set == 4'b1010, "R11 ipi mask fan-out", 32'(ipi_set), 32'hA);
        chk(ipi_id == 4'd15, "R11 ipi id", 32'(ipi_id), 15);
        @(negedge clk);
        reg_addr = 16'h0000; reg_wdata = 32'h0000_0A0F;
        #1;
        chk(ipi_set == '0, "R11 other write no ipi", 32'(ipi_set), 0);
        @(negedge clk);
        reg_wr_en = 1'b0;

        // Routing word address of index 2 after a fresh reset
        irq_line = '0;
        do_reset();
        #1;
        chk(irq_req == '0, "R5 reset clears enable", 32'(irq_req), 0);
        wr(16'h0000, 32'h1);
        wr(16'h1008, 32'h8000_0003);
        irq_line[2] = 1'b1;
        #1;
        chk(irq_req == 4'b1000, "R1 index 2 routed to processor 3", 32'(irq_req), 32'h8);
        chk(id_of(3) == 8'd34, "R1 id of index 2", 32'(id_of(3)), 34);
        wr(16'h1004, 32'h8000_0000);
        irq_line[1] = 1'b1;
        #1;
        chk(irq_req == 4'b1001, "R1 index 1 routed, others untouched", 32'(irq_req), 32'h9);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule